// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit timer channel that advances on a clock-enable strobe inside one clock domain. Software-side logic loads a count value together with a 3-bit operating mode; the channel then produces a mode-dependent waveform on its output pin and continuously reports its current count. An external latch can sample `count_o` in any cycle, because the count is valid every cycle.

Six behaviours are selectable. Two are one-shot and end with a level change: terminal-count interrupt and gate-triggered one-shot. Two are periodic: rate generator and square wave. Two are one-shot and end with a single-tick strobe: software-started and gate-restartable. A rising edge on `gate_i` restarts counting in the gate-sensitive modes. In the other modes the gate has no effect.

Top module: `interval_counter`

## Requirements
- R1: A load with `load_val_i` = 0 acts as a count N of 65536. The reported count right after such a load is 0. In mode 0 the output rises after exactly 65536 ticks.
- R2: Mode 0 (`mode_i`=0): the output is low after a load. It goes high on the tick where the elapsed ticks d reach N and stays high until the next load.
- R3: Mode 1 (`mode_i`=1): after a load the channel waits with the output high and the count at N. A rising gate edge starts counting, and the output stays low while d < N. It is high again once d reaches N, and each later gate rise starts the interval again.
- R4: Mode 2 (`mode_i`=2): the count reloads every N ticks. The output is high for one tick at each period boundary where d is a nonzero multiple of N, and is never high at the load instant. The reported count is N - (d mod N), modulo 65536.
- R5: Mode 3 (`mode_i`=3): the output is high while (d mod N) < ceil(N/2) and low otherwise. The reported count is N - (2d mod N), modulo 65536, so it falls by two per tick.
- R6: Modes 4 and 5 (`mode_i`=4, 5): the output is high only while d equals N, for exactly one tick, and the pulse does not repeat.
- R7: A rising edge of `gate_i` sets d to 0 in modes 1, 2, 3 and 5. In modes 0 and 4 a gate edge leaves both count and output unchanged.
- R8: In modes 0, 1, 4 and 5 the reported count is (N - d) mod 65536. This includes the wrap past zero after terminal count.
- R9: After reset the channel is in mode 3 with N = 65536 and d = 0. The count reads 0 and the output is high.
- R10: d advances by one only on a cycle with `ce_i` high. Without a load, a tick or a gate edge, count and output hold.
- R11: In one cycle, a load takes precedence over a gate rise and over a tick, and leaves d = 0. A gate restart takes precedence over a tick.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Counter tick enable |
| load_i | input | 1 | Load strobe for count value and mode |
| load_val_i | input | 16 | Count value to load (0 means 65536) |
| mode_i | input | 3 | Operating mode, sampled with the load |
| gate_i | input | 1 | Gate level; rising edge restarts in gate-sensitive modes |
| count_o | output | 16 | Current count value |
| out_o | output | 1 | Output pin level |

## Verification
Three events can land in the same cycle: a load, a gate rising edge and a counter tick. The bench drives each pair together on purpose. It loads mode 1 while the gate rises and expects the channel to stay waiting with a high output. It loads while the tick is asserted and expects d = 0 afterwards. It raises the gate in mode 2 together with a tick and expects the count to show N, not N - 1. A reference model in the bench evaluates the elapsed-tick formulas of R2 to R8 on every cycle and judges the outputs against them.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [2:0] {
    M_TERM      = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } ic_mode_e;

  // codes 6/7 alias onto 2/3
  function automatic ic_mode_e fold_mode(input logic [2:0] m);
    if (m[1]) return ic_mode_e'({1'b0, m[1:0]});
    return ic_mode_e'(m);
  endfunction

  function automatic logic is_periodic(input ic_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic gate_restarts(input ic_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STROBE);
  endfunction
endpackage

// File: rtl/ic_core.sv
module ic_core
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [2:0]       mode_i,
  input  logic             gate_i,
  output ic_mode_e         mode_o,
  output logic [CNT_W:0]   reload_o,
  output logic [CNT_W:0]   cnt_o,
  output logic             started_o,
  output logic             gone_o,
  output logic             run_o
);
  localparam int RW = CNT_W + 1;
  localparam logic [RW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [RW-1:0] ONE  = RW'(1);

  ic_mode_e      mode_q, new_mode;
  logic [RW-1:0] reload_q, cnt_q, load_n, inc, cnt_nxt;
  logic          gate_q, started_q, gone_q, run_q;
  logic          rise, restart, tick, periodic;

  always_comb begin
    new_mode = fold_mode(mode_i);
    load_n   = (load_val_i == '0) ? FULL : {1'b0, load_val_i};
    periodic = is_periodic(mode_q);
    rise     = gate_i & ~gate_q;
    restart  = rise & gate_restarts(mode_q) & ~load_i;
    tick     = ce_i & run_q & ~load_i & ~restart;
    inc      = cnt_q + ONE;
    // periodic: phase counts up mod N; one-shot: remainder counts down mod 2^RW
    cnt_nxt  = periodic ? ((inc == reload_q) ? '0 : inc) : (cnt_q - ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q    <= 1'b0;
      mode_q    <= M_SQUARE;
      reload_q  <= FULL;
      cnt_q     <= '0;
      started_q <= 1'b0;
      gone_q    <= 1'b0;
      run_q     <= 1'b1;
    end else begin
      gate_q <= gate_i;
      if (load_i) begin
        mode_q    <= new_mode;
        reload_q  <= load_n;
        cnt_q     <= is_periodic(new_mode) ? '0 : load_n;
        started_q <= 1'b0;
        gone_q    <= 1'b0;
        run_q     <= (new_mode != M_ONESHOT);
      end else if (restart) begin
        cnt_q     <= periodic ? '0 : reload_q;
        started_q <= 1'b0;
        gone_q    <= 1'b0;
        run_q     <= 1'b1;
      end else if (tick) begin
        cnt_q     <= cnt_nxt;
        started_q <= 1'b1;
        if (!periodic && cnt_q == '0) gone_q <= 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign reload_o  = reload_q;
  assign cnt_o     = cnt_q;
  assign started_o = started_q;
  assign gone_o    = gone_q;
  assign run_o     = run_q;
endmodule

// File: rtl/ic_decode.sv
module ic_decode
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  ic_mode_e         mode_i,
  input  logic [CNT_W:0]   reload_i,
  input  logic [CNT_W:0]   cnt_i,
  input  logic             started_i,
  input  logic             gone_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  localparam int RW = CNT_W + 1;

  logic [RW:0]   dbl, red;
  logic [RW-1:0] half_n, rate_cnt, sq_cnt;
  logic          zero;

  always_comb begin
    zero     = (cnt_i == '0);
    half_n   = (reload_i + RW'(1)) >> 1;
    rate_cnt = reload_i - cnt_i;
    dbl      = {cnt_i, 1'b0};
    red      = (dbl >= {1'b0, reload_i}) ? dbl - {1'b0, reload_i} : dbl;
    sq_cnt   = reload_i - red[RW-1:0];
    count_o  = cnt_i[CNT_W-1:0];
    out_o    = 1'b0;
    unique case (mode_i)
      M_TERM:    out_o = zero | gone_i;
      M_ONESHOT: out_o = ~run_i | zero | gone_i;
      M_RATE: begin
        out_o   = zero & started_i;
        count_o = rate_cnt[CNT_W-1:0];
      end
      M_SQUARE: begin
        out_o   = (cnt_i < half_n);
        count_o = sq_cnt[CNT_W-1:0];
      end
      default:   out_o = zero & ~gone_i;
    endcase
  end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [2:0]       mode_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  ic_mode_e     mode;
  logic [CNT_W:0] reload, cnt;
  logic         started, gone, run;

  ic_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .ce_i, .load_i, .load_val_i, .mode_i, .gate_i,
    .mode_o(mode), .reload_o(reload), .cnt_o(cnt),
    .started_o(started), .gone_o(gone), .run_o(run)
  );

  ic_decode #(.CNT_W(CNT_W)) u_dec (
    .mode_i(mode), .reload_i(reload), .cnt_i(cnt),
    .started_i(started), .gone_i(gone), .run_i(run),
    .count_o, .out_o
  );
endmodule

// File: rtl/interval_counter_chk.sv
module interval_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic [2:0]       mode_i,
  input logic             gate_i,
  input logic [CNT_W-1:0] count_o,
  input logic             out_o
);
  logic       gate_d, seen_q;
  logic [2:0] m_q;
  logic [2:0] m_in;
  logic       rise;

  assign m_in = mode_i[1] ? {1'b0, mode_i[1:0]} : mode_i;
  assign rise = gate_i & ~gate_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d <= 1'b0;
      seen_q <= 1'b0;
      m_q    <= 3'd3;
    end else begin
      gate_d <= gate_i;
      seen_q <= 1'b1;
      if (load_i) m_q <= m_in;
    end
  end

  assert_reset_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (count_o == '0) && out_o);

  assert_hold_without_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i && !load_i && !rise |=> $stable(count_o) && $stable(out_o));

  assert_gate_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_q == 3'd0 || m_q == 3'd4) && !load_i && !ce_i |=> $stable(count_o) && $stable(out_o));

  assert_term_low_after_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && m_in == 3'd0 |=> !out_o);

  assert_oneshot_waits_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && m_in == 3'd1 |=> out_o);

  assert_rate_no_pulse_at_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && m_in == 3'd2 |=> !out_o);

  assert_square_starts_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && m_in == 3'd3 |=> out_o);

  assert_strobe_low_after_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && m_in[2] |=> !out_o);

  assert_oneshot_count_loaded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !m_in[1] |=> count_o == $past(load_val_i));

  assert_zero_load_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && load_val_i == '0 |=> count_o == '0);
endmodule

bind interval_counter interval_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_interval_counter.sv
module tb_interval_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, load = 1'b0, gate = 1'b0;
  logic [15:0] val = '0;
  logic [2:0]  mode = '0;
  logic [15:0] count;
  logic        outp;

  int n_chk = 0, n_bad = 0;
  int m_n = 65536, m_d = 0, m_md = 3;
  bit m_run = 1'b1, m_gp = 1'b0;

  always #4 clk = ~clk;

  interval_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .load_i(load), .load_val_i(val),
    .mode_i(mode), .gate_i(gate), .count_o(count), .out_o(outp)
  );

  // {mode, value, cycles, ce divider, gate pulse index (0 = none)}
  localparam int NV = 15;
  localparam logic [38:0] VECS [NV] = '{
    {3'd0, 16'd5, 8'd20, 4'd1, 8'd0},
    {3'd0, 16'd4, 8'd16, 4'd1, 8'd2},
    {3'd1, 16'd6, 8'd24, 4'd1, 8'd3},
    {3'd1, 16'd3, 8'd30, 4'd2, 8'd20},
    {3'd2, 16'd5, 8'd30, 4'd1, 8'd0},
    {3'd2, 16'd4, 8'd30, 4'd1, 8'd9},
    {3'd3, 16'd6, 8'd30, 4'd1, 8'd0},
    {3'd3, 16'd5, 8'd30, 4'd1, 8'd0},
    {3'd3, 16'd7, 8'd40, 4'd3, 8'd12},
    {3'd4, 16'd5, 8'd20, 4'd1, 8'd2},
    {3'd5, 16'd4, 8'd20, 4'd1, 8'd8},
    {3'd6, 16'd3, 8'd16, 4'd1, 8'd0},
    {3'd7, 16'd4, 8'd16, 4'd1, 8'd0},
    {3'd1, 16'd1, 8'd10, 4'd1, 8'd2},
    {3'd2, 16'd1, 8'd8,  4'd1, 8'd0}
  };

  function automatic string tag_of(int md);
    case (md)
      0: return "R2/R8";
      1: return "R3/R7";
      2: return "R4/R7";
      3: return "R5/R7";
      6: return "R12";
      7: return "R12";
      default: return "R6/R7";
    endcase
  endfunction

  task automatic check(string tag);
    logic [15:0] ec;
    logic        eo;
    int          ph;
    ph = m_d % m_n;
    ec = 16'(m_n - m_d);
    case (m_md)
      0: eo = (m_d >= m_n);
      1: eo = !m_run || (m_d >= m_n);
      2: begin ec = 16'(m_n - ph); eo = (ph == 0) && (m_d != 0); end
      3: begin ec = 16'(m_n - ((2 * m_d) % m_n)); eo = ph < ((m_n + 1) / 2); end
      default: eo = (m_d == m_n);
    endcase
    n_chk++;
    if (count !== ec || outp !== eo) begin
      n_bad++;
      $display("FAIL %s: count=%0d out=%0b expected count=%0d out=%0b (d=%0d)",
               tag, count, outp, ec, eo, m_d);
    end
  endtask

  task automatic step(bit ld, logic [15:0] v, logic [2:0] m, bit g, bit c, string tag);
    bit rise;
    @(negedge clk);
    load = ld; val = v; mode = m; gate = g; ce = c;
    rise = g && !m_gp;
    if (ld) begin
      m_n = (v == 0) ? 65536 : int'(v);
      m_md = m[1] ? int'(m[1:0]) : int'(m);
      m_d = 0;
      m_run = (m_md != 1);
    end else if (rise && (m_md == 1 || m_md == 2 || m_md == 3 || m_md == 5)) begin
      m_d = 0;
      m_run = 1'b1;
    end else if (c && m_run) begin
      m_d++;
    end
    m_gp = g;
    @(posedge clk);
    #2;
    check(tag);
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9");
    // reset state counts as square wave of 65536, steps by two
    for (int i = 0; i < 4; i++) step(0, 16'd0, 3'd0, 0, 1, "R9/R5");
    step(0, 16'd0, 3'd0, 0, 0, "R10");
    step(0, 16'd0, 3'd0, 0, 0, "R10");

    for (int k = 0; k < NV; k++) begin
      logic [2:0]  vm;
      logic [15:0] vv;
      int          cy, dv, ga;
      vm = VECS[k][38:36]; vv = VECS[k][35:20];
      cy = int'(VECS[k][19:12]); dv = int'(VECS[k][11:8]); ga = int'(VECS[k][7:0]);
      step(1, vv, vm, 0, 0, tag_of(int'(vm)));
      for (int c = 0; c < cy; c++)
        step(0, vv, vm, (ga != 0) && (c == ga || c == ga + 1), (c % dv) == 0, tag_of(int'(vm)));
      step(0, vv, vm, 0, 0, tag_of(int'(vm)));
    end

    // load together with tick: load wins, d stays 0
    step(1, 16'd9, 3'd0, 0, 1, "R11");
    step(0, 16'd9, 3'd0, 0, 1, "R11");
    // mode 1 load together with gate rise: stays waiting
    step(0, 16'd9, 3'd0, 0, 0, "R11");
    step(1, 16'd3, 3'd1, 1, 1, "R11");
    step(0, 16'd3, 3'd1, 1, 1, "R11");
    step(0, 16'd3, 3'd1, 0, 1, "R3");
    step(0, 16'd3, 3'd1, 1, 1, "R3");
    for (int i = 0; i < 5; i++) step(0, 16'd3, 3'd1, 1, 1, "R3");
    // gate rise together with tick in mode 2: restart wins
    step(1, 16'd6, 3'd2, 0, 0, "R11");
    step(0, 16'd6, 3'd2, 0, 1, "R11");
    step(0, 16'd6, 3'd2, 0, 1, "R11");
    step(0, 16'd6, 3'd2, 1, 1, "R11");
    step(0, 16'd6, 3'd2, 1, 1, "R4");
    // count wraps past terminal in one-shot modes
    step(1, 16'd2, 3'd4, 0, 0, "R8");
    for (int i = 0; i < 6; i++) step(0, 16'd2, 3'd4, 0, 1, "R8/R6");
    // zero load means 65536 ticks
    step(1, 16'd0, 3'd0, 0, 0, "R1");
    for (int i = 0; i < 65538; i++) step(0, 16'd0, 3'd0, 0, 1, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule